// File: doc/BRIEF.md
# Single-Level DMA Address Translation Walker

This block turns a device DMA address into a physical address through one lookup in a translation table held in system memory. A request carries a virtual address. The block combines it with the current control word and the table base address. When translation is on, the block works out where the matching 8-byte entry sits, issues one memory read for it, and turns the returned entry into a response. The response holds the physical page address, the virtual page address, the in-page offset mask and a permission code.

The table can be indexed in units of 8 KiB or 64 KiB pages. A 3-bit size code sets how many address bits take part in the index. Each entry carries its own mapping size bit, so a table indexed by 8 KiB pages may still map 64 KiB pages, and the reverse. When translation is off, the address passes through unchanged. The walker handles one translation at a time. Configuration is sampled when a request is accepted, so later changes cannot disturb a walk that is already running.

Top module: `ioTableWalk`

## Requirements
- R1: When control bit 0 is clear at acceptance, the response returns the request address as the physical address, with page address equal to the address with bits 12:0 cleared, offset mask 0x1FFF and permission read-write. No memory read is issued, and the other control bits have no effect.
- R2: With control bit 0 set and control bit 2 clear (8 KiB indexing), size code c in control bits 18:16 (0..7) selects address bits 22+c down to 13 as the entry number. The entry byte offset is that number times 8.
- R3: With control bits 0 and 2 set (64 KiB indexing), size code c in 0..5 selects address bits 25+c down to 16 as the entry number. The entry byte offset is that number times 8.
- R4: With 64 KiB indexing and size code 6 or 7, no memory read is issued and the response has permission none.
- R5: The single memory read is made at table base plus entry byte offset. The returned 64-bit entry uses bit 63 as its most significant bit, which is the first byte in memory.
- R6: An entry with bit 63 clear gives permission none. A none response always carries physical address 0, page address 0 and offset mask all ones.
- R7: Permission codes are none = 2'b00, read-only = 2'b01 and read-write = 2'b11. A valid entry gives read-write when entry bit 1 is set and read-only when it is clear.
- R8: A valid entry with bit 61 set maps 64 KiB: physical address = entry bits 40:15 with bits 14:0 zero, mask 0xFFFF, page address = request address with bits 15:0 cleared. With bit 61 clear it maps 8 KiB: physical = entry bits 40:13 with bits 12:0 zero, mask 0x1FFF, page address with bits 12:0 cleared.
- R9: A memory response flagged as error gives permission none, whatever the data.
- R10: A request is accepted only while the walker is idle. The response stays valid and unchanged until it is accepted. Control, base and address inputs that change after acceptance do not affect that translation.
- R11: After reset, and after a reset in the middle of a walk, the walker is idle: request ready high, response valid low, memory request valid low.
- R12: A response that needs no memory read is valid in the cycle after acceptance. For a walk, the memory request is valid in the cycle after acceptance, and the response is valid in the cycle after the memory data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqAddr | input | VA_W | Virtual DMA address |
| ctrlReg | input | 32 | Control word: bit 0 enable, bit 2 64 KiB indexing, bits 18:16 size code |
| tableBase | input | PA_W | Physical base address of the translation table |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | PA_W | Byte address of the entry |
| memRespValid | input | 1 | Entry data returned |
| memRespData | input | 64 | Entry word, bit 63 most significant |
| memRespErr | input | 1 | Memory read failed |
| respValid | output | 1 | Translation result present |
| respReady | input | 1 | Consumer takes the result |
| respPhys | output | PA_W | Physical page address, or pass-through address |
| respPage | output | VA_W | Virtual page address |
| respMask | output | VA_W | In-page offset mask |
| respPerm | output | 2 | Permission code |

## Verification
Results that need no memory read, which are pass-through and unsupported size codes, are due in the cycle after acceptance. For a walk, the entry address is due in the cycle after acceptance and the result in the cycle after the data is returned. The bench drives each input on a falling edge and samples on the next falling edge after the edge that should produce the result. This way every check lands on the exact cycle that R12 names, and a result that arrives early or late fails. After each acceptance the bench also scrambles the control, base and address inputs, and it holds back the response ready for one cycle. This confirms that the result is taken from the values sampled at acceptance and stays stable until it is consumed.

// File: rtl/ioWalkPkg.sv
package ioWalkPkg;
  // control word fields
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_BIG_BIT = 2;
  localparam int CTRL_SIZE_LSB = 16;
  localparam int SIZE_W = 3;
  // index geometry
  localparam int SMALL_SHIFT = 13;
  localparam int LARGE_SHIFT = 16;
  localparam int LARGE_MAP_SHIFT = 15;
  localparam int ENTRY_BYTES_LOG = 3;
  localparam int SMALL_WIN_LOG = 23;
  localparam int LARGE_WIN_LOG = 26;
  localparam int LARGE_MAX_CODE = 5;
  // entry fields
  localparam int ENTRY_W = 64;
  localparam int ENTRY_VALID_BIT = 63;
  localparam int ENTRY_LARGE_BIT = 61;
  localparam int ENTRY_WRITE_BIT = 1;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } permT;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_FAULT = 2'd1,
    KIND_WALK  = 2'd2
  } kindT;

  typedef struct packed {
    logic capture;
    logic latchEntry;
  } walkStrobeT;
endpackage

// File: rtl/ioWalkPath.sv
module ioWalkPath
  import ioWalkPkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 41
) (
  input  logic            clk,
  input  logic            rstN,
  input  walkStrobeT      strobe,
  input  logic [VA_W-1:0] reqAddr,
  input  logic [31:0]     ctrlReg,
  input  logic [PA_W-1:0] tableBase,
  input  logic [ENTRY_W-1:0] memRespData,
  input  logic            memRespErr,
  output kindT            liveKind,
  output logic [PA_W-1:0] memReqAddr,
  output logic [PA_W-1:0] respPhys,
  output logic [VA_W-1:0] respPage,
  output logic [VA_W-1:0] respMask,
  output permT            respPerm
);
  localparam logic [VA_W-1:0] SMALL_MASK = VA_W'((64'd1 << SMALL_SHIFT) - 64'd1);
  localparam logic [VA_W-1:0] LARGE_MASK = VA_W'((64'd1 << LARGE_SHIFT) - 64'd1);

  logic [VA_W-1:0]         addrQ;
  logic [PA_W-1:0]         baseQ;
  kindT                    kindQ;
  logic                    bigQ;
  logic [SIZE_W-1:0]       sizeQ;
  logic                    validQ, largeQ, writeQ, errQ;
  logic [PA_W-1:SMALL_SHIFT] physFieldQ;

  logic [SIZE_W-1:0] liveSize;
  assign liveSize = ctrlReg[CTRL_SIZE_LSB +: SIZE_W];

  always_comb begin
    if (!ctrlReg[CTRL_EN_BIT]) liveKind = KIND_PASS;
    else if (ctrlReg[CTRL_BIG_BIT] && (int'(liveSize) > LARGE_MAX_CODE)) liveKind = KIND_FAULT;
    else liveKind = KIND_WALK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; baseQ <= '0; kindQ <= KIND_PASS; bigQ <= 1'b0; sizeQ <= '0;
      validQ <= 1'b0; largeQ <= 1'b0; writeQ <= 1'b0; errQ <= 1'b0; physFieldQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= reqAddr;
      baseQ <= tableBase;
      kindQ <= liveKind;
      bigQ <= ctrlReg[CTRL_BIG_BIT];
      sizeQ <= liveSize;
      validQ <= 1'b0; largeQ <= 1'b0; writeQ <= 1'b0; errQ <= 1'b0; physFieldQ <= '0;
    end else if (strobe.latchEntry) begin
      validQ <= memRespData[ENTRY_VALID_BIT];
      largeQ <= memRespData[ENTRY_LARGE_BIT];
      writeQ <= memRespData[ENTRY_WRITE_BIT];
      errQ <= memRespErr;
      physFieldQ <= memRespData[PA_W-1:SMALL_SHIFT];
    end
  end

  // entry address: index bits between page shift and window top, scaled by entry size
  int winLog, pageShift;
  logic [VA_W-1:0] winMask, entryOffset;
  always_comb begin
    winLog = (bigQ ? LARGE_WIN_LOG : SMALL_WIN_LOG) + int'(sizeQ);
    pageShift = bigQ ? LARGE_SHIFT : SMALL_SHIFT;
    winMask = VA_W'((64'd1 << winLog) - 64'd1);
    entryOffset = ((addrQ & winMask) >> pageShift) << ENTRY_BYTES_LOG;
    memReqAddr = baseQ + PA_W'(entryOffset);
  end

  always_comb begin
    respPhys = '0;
    respPage = '0;
    respMask = '1;
    respPerm = PERM_NONE;
    if (kindQ == KIND_PASS) begin
      respPhys = PA_W'(addrQ);
      respMask = SMALL_MASK;
      respPage = addrQ & ~SMALL_MASK;
      respPerm = PERM_RW;
    end else if (kindQ == KIND_WALK && validQ && !errQ) begin
      respPerm = writeQ ? PERM_RW : PERM_RO;
      if (largeQ) begin
        respPhys = {physFieldQ[PA_W-1:LARGE_MAP_SHIFT], {LARGE_MAP_SHIFT{1'b0}}};
        respMask = LARGE_MASK;
        respPage = addrQ & ~LARGE_MASK;
      end else begin
        respPhys = {physFieldQ, {SMALL_SHIFT{1'b0}}};
        respMask = SMALL_MASK;
        respPage = addrQ & ~SMALL_MASK;
      end
    end
  end

  // R6
  none_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respPerm == PERM_NONE) |-> (respPhys == '0 && respPage == '0 && respMask == '1));
endmodule

// File: rtl/ioWalkCtrl.sv
module ioWalkCtrl
  import ioWalkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  kindT       liveKind,
  output logic       memReqValid,
  input  logic       memReqReady,
  input  logic       memRespValid,
  output logic       respValid,
  input  logic       respReady,
  output walkStrobeT strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} stateT;
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNext = (liveKind == KIND_WALK) ? ST_FETCH : ST_RESP;
      end
      ST_FETCH: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRespValid) begin
        strobe.latchEntry = 1'b1;
        stateNext = ST_RESP;
      end
      ST_RESP: if (respReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);
  assign memReqValid = (state == ST_FETCH);
  assign respValid = (state == ST_RESP);

  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!respValid && !memReqValid));
  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> respValid);
  // R12
  data_to_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && memRespValid) |=> respValid);
endmodule

// File: rtl/ioTableWalk.sv
module ioTableWalk
  import ioWalkPkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 41
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqAddr,
  input  logic [31:0]     ctrlReg,
  input  logic [PA_W-1:0] tableBase,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [PA_W-1:0] memReqAddr,
  input  logic            memRespValid,
  input  logic [63:0]     memRespData,
  input  logic            memRespErr,
  output logic            respValid,
  input  logic            respReady,
  output logic [PA_W-1:0] respPhys,
  output logic [VA_W-1:0] respPage,
  output logic [VA_W-1:0] respMask,
  output logic [1:0]      respPerm
);
  walkStrobeT strobe;
  kindT liveKind;
  permT permOut;

  ioWalkCtrl ctrlU (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .liveKind(liveKind), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRespValid(memRespValid), .respValid(respValid), .respReady(respReady),
    .strobe(strobe)
  );

  ioWalkPath #(.VA_W(VA_W), .PA_W(PA_W)) pathU (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .ctrlReg(ctrlReg),
    .tableBase(tableBase), .memRespData(memRespData), .memRespErr(memRespErr),
    .liveKind(liveKind), .memReqAddr(memReqAddr), .respPhys(respPhys),
    .respPage(respPage), .respMask(respMask), .respPerm(permOut)
  );

  assign respPerm = permOut;

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !ctrlReg[CTRL_EN_BIT]) |=>
      (respValid && !memReqValid && respPerm == 2'b11 && respPhys == PA_W'($past(reqAddr))));
  // R4
  unsupported_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && ctrlReg[CTRL_EN_BIT] && ctrlReg[CTRL_BIG_BIT] &&
     ctrlReg[CTRL_SIZE_LSB+2] && ctrlReg[CTRL_SIZE_LSB+1]) |=>
      (respValid && !memReqValid && respPerm == 2'b00));
  // R10
  resp_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> ($stable(respPhys) && $stable(respPerm) && $stable(respMask)));
endmodule

// File: tb/ioTableWalk_test.sv
module ioTableWalk_test;
  localparam int VA_W = 32;
  localparam int PA_W = 41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, memReqReady = 1'b1, memRespValid = 1'b0, memRespErr = 1'b0, respReady = 1'b0;
  logic [VA_W-1:0] reqAddr = '0;
  logic [31:0] ctrlReg = '0;
  logic [PA_W-1:0] tableBase = '0;
  logic [63:0] memRespData = '0;
  logic reqReady, memReqValid, respValid;
  logic [PA_W-1:0] memReqAddr, respPhys;
  logic [VA_W-1:0] respPage, respMask;
  logic [1:0] respPerm;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ioTableWalk #(.VA_W(VA_W), .PA_W(PA_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .ctrlReg(ctrlReg), .tableBase(tableBase), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .memRespErr(memRespErr), .respValid(respValid),
    .respReady(respReady), .respPhys(respPhys), .respPage(respPage),
    .respMask(respMask), .respPerm(respPerm)
  );

  typedef struct packed {
    logic [31:0]     ctrl;
    logic [PA_W-1:0] base;
    logic [VA_W-1:0] addr;
    logic [63:0]     entry;
    logic            err;
    logic            doFetch;
    logic [PA_W-1:0] fetchAddr;
    logic [PA_W-1:0] phys;
    logic [VA_W-1:0] page;
    logic [VA_W-1:0] mask;
    logic [1:0]      perm;
  } vecT;

  localparam int NVEC = 11;
  localparam vecT VECS [NVEC] = '{
    '{32'h0000_0000, 41'h0, 32'h1234_5678, 64'h0, 1'b0, 1'b0, 41'h0,
      41'h0_1234_5678, 32'h1234_4000, 32'h0000_1FFF, 2'b11},
    '{32'h0000_0001, 41'h1_0000_0000, 32'h0076_A000, 64'h8004_01AB_CDE0_3002, 1'b0, 1'b1, 41'h1_0000_1DA8,
      41'h1AB_CDE0_2000, 32'h0076_A000, 32'h0000_1FFF, 2'b11},
    '{32'h0000_0001, 41'h200, 32'h0F76_A000, 64'hA000_0000_0123_C000, 1'b0, 1'b1, 41'h1FA8,
      41'h0123_8000, 32'h0F76_0000, 32'h0000_FFFF, 2'b01},
    '{32'h0007_0001, 41'h0, 32'hFFFF_E000, 64'h0000_0000_0000_2002, 1'b0, 1'b1, 41'hF_FFF8,
      41'h0, 32'h0, 32'hFFFF_FFFF, 2'b00},
    '{32'h0000_0005, 41'h0_8000_0000, 32'h03FF_1234, 64'h8000_0000_ABCD_E002, 1'b0, 1'b1, 41'h8000_1FF8,
      41'hABCD_E000, 32'h03FF_0000, 32'h0000_1FFF, 2'b11},
    '{32'h0005_0005, 41'h1_0000_0000, 32'hC123_4567, 64'h8000_0000_0000_0002, 1'b1, 1'b1, 41'h1_0002_0918,
      41'h0, 32'h0, 32'hFFFF_FFFF, 2'b00},
    '{32'h0006_0005, 41'h1000, 32'h0001_0000, 64'h0, 1'b0, 1'b0, 41'h0,
      41'h0, 32'h0, 32'hFFFF_FFFF, 2'b00},
    '{32'h0007_0005, 41'h1000, 32'h7FFF_0000, 64'h0, 1'b0, 1'b0, 41'h0,
      41'h0, 32'h0, 32'hFFFF_FFFF, 2'b00},
    '{32'h0003_0001, 41'h100, 32'h02AA_C000, 64'h8000_0000_0000_4000, 1'b0, 1'b1, 41'hABB0,
      41'h4000, 32'h02AA_C000, 32'h0000_1FFF, 2'b01},
    '{32'h0006_0004, 41'h0, 32'hFFFF_FFFF, 64'h0, 1'b0, 1'b0, 41'h0,
      41'h0_FFFF_FFFF, 32'hFFFF_E000, 32'h0000_1FFF, 2'b11},
    '{32'h0002_0005, 41'h0, 32'h0FED_8000, 64'hA000_01FF_FFFF_8002, 1'b0, 1'b1, 41'h7F68,
      41'h1FF_FFFF_8000, 32'h0FED_0000, 32'h0000_FFFF, 2'b11}
  };
  localparam string TAGS [NVEC] = '{"R1", "R2 R8 R7", "R2 R8 R7", "R2 R6", "R3 R5 R8",
                                    "R3 R9", "R4", "R4", "R2 R7", "R1", "R3 R8 R7"};

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runVec(input vecT v, input string tag);
    @(negedge clk);
    ctrlReg = v.ctrl; tableBase = v.base; reqAddr = v.addr; reqValid = 1'b1;
    check(reqReady == 1'b1, {tag, " R10 idle ready"}, 64'(reqReady), 64'd1);
    @(negedge clk);
    // acceptance edge passed; scramble inputs (R10)
    reqValid = 1'b0; ctrlReg = 32'h0007_0004; tableBase = '1; reqAddr = 32'hDEAD_BEEF;
    check(reqReady == 1'b0, {tag, " R10 busy not ready"}, 64'(reqReady), 64'd0);
    if (v.doFetch) begin
      check(memReqValid && !respValid, {tag, " R12 fetch next cycle"}, 64'({memReqValid, respValid}), 64'b10);
      check(memReqAddr == v.fetchAddr, {tag, " R5 entry address"}, 64'(memReqAddr), 64'(v.fetchAddr));
      @(negedge clk);
      check(!memReqValid && !respValid, {tag, " R12 one fetch only"}, 64'({memReqValid, respValid}), 64'b00);
      memRespValid = 1'b1; memRespData = v.entry; memRespErr = v.err;
      @(negedge clk);
      memRespValid = 1'b0; memRespData = '0; memRespErr = 1'b0;
    end else begin
      check(!memReqValid, {tag, " no memory read"}, 64'(memReqValid), 64'd0);
    end
    check(respValid == 1'b1, {tag, " R12 response due"}, 64'(respValid), 64'd1);
    check(respPhys == v.phys, {tag, " phys"}, 64'(respPhys), 64'(v.phys));
    check(respPage == v.page, {tag, " page"}, 64'(respPage), 64'(v.page));
    check(respMask == v.mask, {tag, " mask"}, 64'(respMask), 64'(v.mask));
    check(respPerm == v.perm, {tag, " perm"}, 64'(respPerm), 64'(v.perm));
    @(negedge clk);
    check(respValid && respPhys == v.phys && respPerm == v.perm, {tag, " R10 held"},
          64'({respValid, respPerm}), 64'({1'b1, v.perm}));
    respReady = 1'b1;
    @(negedge clk);
    respReady = 1'b0;
    check(!respValid && reqReady, {tag, " R10 back to idle"}, 64'({respValid, reqReady}), 64'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(reqReady && !respValid && !memReqValid, "R11 in reset",
          64'({reqReady, respValid, memReqValid}), 64'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !respValid && !memReqValid, "R11 after reset",
          64'({reqReady, respValid, memReqValid}), 64'b100);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], TAGS[i]);

    // R11: reset in the middle of a walk
    @(negedge clk);
    ctrlReg = 32'h0000_0001; tableBase = 41'h40; reqAddr = 32'h0000_2000; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(memReqValid == 1'b1, "R11 walk started", 64'(memReqValid), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    check(reqReady && !respValid && !memReqValid, "R11 mid-walk reset",
          64'({reqReady, respValid, memReqValid}), 64'b100);
    rstN = 1'b1;
    @(negedge clk);
    runVec(VECS[0], "R11 R1 recovery");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule